// File: doc/BRIEF.md
# Host Authentication Transaction Sequencer

This block runs one complete authentication transaction, from the host side, against a security device on a half-duplex single-wire bus. It works one token at a time. It asks a line driver for wake, transmit, command-flag, data and sleep tokens. It sends a command block from a small local buffer, checks the response blocks the driver hands back, and reports one result when the transaction ends. Bit-level line coding, CRC computation and the command content belong to the surrounding logic. The CRC result arrives as a single valid flag at the end of each received block.

The host loads the command buffer, selects the long or short wait schedule, and pulses `start`. The sequencer first wakes the device and confirms that it is synchronized. If the device stays silent, it climbs a recovery ladder of longer and longer idle periods. It splits the session with a sleep and a fresh wake when the command would not fit inside the device watchdog window. Long commands get an early error probe after parsing, and short commands get a single combined wait. A read that fails CRC is repeated a limited number of times. Every transaction ends with a sleep token and a one-cycle `done` pulse.

Top module: `host_auth_seq`

## Requirements
- R1: After `start`, a wake token is issued, then a wait of T_WAKE cycles, then a transmit token. A reply with good CRC whose second byte (index 1) is 0x11 leads to a command-flag token, followed by `cmd_len` data tokens carrying buffer entries 0, 1, 2 and onward in address order.
- R2: When the wake reply is missing or wrong, the sequencer idles and then repeats wake, wait and transmit. The idle period is T_TIMEOUT on the first retry, 2×T_TIMEOUT on the second and T_WATCHDOG on the third. A fourth failure ends the transaction with err_code 1.
- R3: For a long command (`cmd_long`=1), the sequencer waits T_PARSE after the last data token and then sends a probe transmit token. Any reply to the probe ends the transaction with err_code 2, and its byte 1 appears on `resp_status`. Silence for T_TIMEOUT is followed by a wait of T_EXEC_LONG and then the read transmit token.
- R4: For a short command, no probe is sent. A single wait of T_SHORT follows the last data token, and then the read transmit token is issued.
- R5: A read reply with bad CRC causes the transmit token to be sent again, up to MAX_REREAD extra times. Once those are used up, the transaction ends with err_code 4.
- R6: A read reply with good CRC is classified as follows. A 4-byte block with status 0x0F gives err_code 3. A 4-byte block with status 0xFF gives err_code 4. Anything else is a success with err_code 0. `resp_status` always carries byte 1 of the reply.
- R7: If no reply byte arrives within T_TIMEOUT of the read transmit token, the transaction ends with err_code 5.
- R8: Every transaction ends with a sleep token, and then `done` is high for exactly one cycle. `success`, `err_code` and `resp_status` stay valid from `done` until the next accepted `start`. After reset all outputs are 0.
- R9: Before the command flag, the sequencer checks the session time. If the elapsed session time plus the estimated command time would exceed T_WATCHDOG, it issues a sleep token and restarts from wake under R1 and R2. This split happens at most once per transaction.
- R10: `tok_req` stays high with `tok_kind` and `tok_data` stable until `tok_done`. The kind codes are wake=0, transmit=1, command flag=2, sleep=3 and data=4.
- R11: A `start` pulse while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transaction (ignored while busy) |
| cmd_long | input | 1 | 1 selects the long schedule with the parse probe |
| cmd_len | input | LW | Number of command block bytes to send |
| buf_we | input | 1 | Command buffer write enable |
| buf_addr | input | IW | Command buffer write address |
| buf_wdata | input | 8 | Command buffer write data |
| tok_req | output | 1 | Token request to the line driver |
| tok_kind | output | 3 | Token kind code |
| tok_data | output | 8 | Byte for data tokens |
| tok_done | input | 1 | Driver finished the current token |
| rx_valid | input | 1 | A received byte is present |
| rx_byte | input | 8 | Received byte |
| rx_end | input | 1 | End of the received block |
| rx_crc_ok | input | 1 | CRC verdict, valid with rx_end |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| success | output | 1 | Transaction succeeded |
| err_code | output | 3 | 0 none, 1 no sync, 2 parse error, 3 exec error, 4 comm failure, 5 no response |
| resp_status | output | 8 | Byte 1 of the deciding reply |

## Verification
The assertions check the following on every cycle: token requests stay stable until the driver acknowledges them, no token is requested while idle, `done` is a single-cycle pulse that directly follows a completed sleep token, and a reported success never carries an error code. The scenarios are the only place where the order of tokens and the length of each wait can be seen. That covers the recovery ladder intervals, the probe on long commands, the number of re-reads, the watchdog split and the classification of status bytes. All of them are judged from the token log kept at the driver side and from the result ports.

// File: rtl/has_pkg.sv
package has_pkg;

  typedef enum logic [2:0] {
    TK_WAKE  = 3'd0,
    TK_XMIT  = 3'd1,
    TK_CMDF  = 3'd2,
    TK_SLEEP = 3'd3,
    TK_DATA  = 3'd4
  } tok_kind_t;

  typedef enum logic [2:0] {
    ER_NONE   = 3'd0,
    ER_NOSYNC = 3'd1,
    ER_PARSE  = 3'd2,
    ER_EXEC   = 3'd3,
    ER_COMM   = 3'd4,
    ER_NORESP = 3'd5
  } err_t;

  typedef enum logic [4:0] {
    S_IDLE, S_WAKE, S_WGAP, S_WXMIT, S_WRESP, S_RSWAIT, S_BUDGET, S_SPLIT,
    S_CFLAG, S_CDATA, S_PWAIT, S_PXMIT, S_PRESP, S_EWAIT, S_RXMIT, S_RRESP,
    S_SLEEP, S_DONE
  } seq_state_t;

  localparam logic [7:0] WAKE_OK_CODE = 8'h11;
  localparam logic [7:0] EXEC_FAIL    = 8'h0F;
  localparam logic [7:0] COMM_FAIL    = 8'hFF;
  localparam logic [7:0] SHORT_BLOCK  = 8'd4;

endpackage

// File: rtl/has_cmd_buf.sv
module has_cmd_buf #(
  parameter int DEPTH = 8,
  parameter int IW    = 3
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [IW-1:0] raddr,
  output logic [7:0]    rdata
);

  logic [7:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (we && (waddr == IW'(g))) begin
        mem[g] <= wdata;
      end
    end
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/has_timer.sv
module has_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);

  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - TW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/has_rx_capture.sv
module has_rx_capture (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  output logic [7:0] blk_count,
  output logic [7:0] blk_status
);

  logic [1:0] pos_q, pos_d;
  logic [7:0] cnt_q, cnt_d, st_q, st_d;

  always_comb begin
    pos_d = pos_q;
    cnt_d = cnt_q;
    st_d  = st_q;
    if (clr) begin
      pos_d = 2'd0;
    end else if (rx_valid) begin
      if (pos_q == 2'd0) cnt_d = rx_byte;
      if (pos_q == 2'd1) st_d  = rx_byte;
      if (pos_q != 2'd3) pos_d = pos_q + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= 2'd0;
      cnt_q <= 8'd0;
      st_q  <= 8'd0;
    end else begin
      pos_q <= pos_d;
      cnt_q <= cnt_d;
      st_q  <= st_d;
    end
  end

  assign blk_count  = cnt_q;
  assign blk_status = st_q;

endmodule

// File: rtl/host_auth_seq.sv
module host_auth_seq
  import has_pkg::*;
#(
  parameter int BUF_DEPTH   = 8,
  parameter int T_PARSE     = 1000,
  parameter int T_EXEC_LONG = 300000,
  parameter int T_SHORT     = 40000,
  parameter int T_TIMEOUT   = 650000,
  parameter int T_WAKE      = 3000,
  parameter int T_WATCHDOG  = 13000000,
  parameter int T_BYTE      = 400,
  parameter int MAX_REREAD  = 2,
  localparam int IW = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1,
  localparam int LW = $clog2(BUF_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          cmd_long,
  input  logic [LW-1:0] cmd_len,
  input  logic          buf_we,
  input  logic [IW-1:0] buf_addr,
  input  logic [7:0]    buf_wdata,
  output logic          tok_req,
  output logic [2:0]    tok_kind,
  output logic [7:0]    tok_data,
  input  logic          tok_done,
  input  logic          rx_valid,
  input  logic [7:0]    rx_byte,
  input  logic          rx_end,
  input  logic          rx_crc_ok,
  output logic          busy,
  output logic          done,
  output logic          success,
  output logic [2:0]    err_code,
  output logic [7:0]    resp_status
);

  localparam int MAXW = T_WATCHDOG + T_EXEC_LONG + T_SHORT + T_PARSE + 2 * T_TIMEOUT + T_WAKE;
  localparam int TW   = $clog2(MAXW + 1);
  localparam int RW   = $clog2(MAX_REREAD + 2);
  localparam int SW   = $clog2(T_WATCHDOG + 1) + 1;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ns = rsync_q[1];

  seq_state_t    state_q, state_d;
  logic [1:0]    att_q, att_d;
  logic [RW-1:0] rd_q, rd_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          split_q, split_d;
  logic          long_q, long_d;
  logic [LW-1:0] len_q, len_d;
  err_t          err_q, err_d;
  logic          succ_q, succ_d;
  logic [7:0]    stat_q, stat_d;
  logic [SW-1:0] sess_q, sess_d;

  logic          tmr_load, tmr_exp;
  logic [TW-1:0] tmr_val;
  logic          rx_clr;
  logic [7:0]    blk_count, blk_status, buf_rdata;
  logic [31:0]   est, sess_ext;
  logic          over_budget, last_byte;

  has_cmd_buf #(.DEPTH(BUF_DEPTH), .IW(IW)) u_buf (
    .clk(clk), .we(buf_we), .waddr(buf_addr), .wdata(buf_wdata),
    .raddr(idx_q), .rdata(buf_rdata)
  );

  has_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst_n(rst_ns), .load(tmr_load), .load_val(tmr_val), .expired(tmr_exp)
  );

  has_rx_capture u_rx (
    .clk(clk), .rst_n(rst_ns), .clr(rx_clr), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .blk_count(blk_count), .blk_status(blk_status)
  );

  // session budget estimate: bytes, waits and one response timeout of margin
  always_comb begin
    est = 32'(len_q) * 32'(T_BYTE) + 32'(T_TIMEOUT) +
          (long_q ? 32'(T_PARSE + T_TIMEOUT + T_EXEC_LONG) : 32'(T_SHORT));
    sess_ext    = 32'(sess_q);
    over_budget = (sess_ext + est) > 32'(T_WATCHDOG);
  end

  assign last_byte = ((LW'(idx_q) + LW'(1)) == len_q);

  always_comb begin
    state_d  = state_q;
    att_d    = att_q;
    rd_d     = rd_q;
    idx_d    = idx_q;
    split_d  = split_q;
    long_d   = long_q;
    len_d    = len_q;
    err_d    = err_q;
    succ_d   = succ_q;
    stat_d   = stat_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    rx_clr   = 1'b0;

    unique case (state_q)
      S_IDLE: begin
        if (start) begin
          long_d  = cmd_long;
          len_d   = cmd_len;
          att_d   = 2'd0;
          rd_d    = '0;
          split_d = 1'b0;
          err_d   = ER_NONE;
          succ_d  = 1'b0;
          stat_d  = 8'd0;
          state_d = S_WAKE;
        end
      end
      S_WAKE: begin
        if (tok_done) begin
          tmr_load = 1'b1;
          tmr_val  = TW'(T_WAKE);
          state_d  = S_WGAP;
        end
      end
      S_WGAP: if (tmr_exp) state_d = S_WXMIT;
      S_WXMIT: begin
        rx_clr = 1'b1;
        if (tok_done) begin
          tmr_load = 1'b1;
          tmr_val  = TW'(T_TIMEOUT);
          state_d  = S_WRESP;
        end
      end
      S_WRESP: begin
        if (rx_end && rx_crc_ok && (blk_status == WAKE_OK_CODE)) begin
          state_d = S_BUDGET;
        end else if (rx_end || (tmr_exp && !rx_valid)) begin
          if (att_q == 2'd3) begin
            err_d   = ER_NOSYNC;
            state_d = S_SLEEP;
          end else begin
            tmr_load = 1'b1;
            unique case (att_q)
              2'd0:    tmr_val = TW'(T_TIMEOUT);
              2'd1:    tmr_val = TW'(2 * T_TIMEOUT);
              default: tmr_val = TW'(T_WATCHDOG);
            endcase
            att_d   = att_q + 2'd1;
            state_d = S_RSWAIT;
          end
        end else if (rx_valid) begin
          tmr_load = 1'b1;
          tmr_val  = TW'(T_TIMEOUT);
        end
      end
      S_RSWAIT: if (tmr_exp) state_d = S_WAKE;
      S_BUDGET: begin
        if (!split_q && over_budget) begin
          split_d = 1'b1;
          state_d = S_SPLIT;
        end else begin
          idx_d   = '0;
          state_d = S_CFLAG;
        end
      end
      S_SPLIT: begin
        if (tok_done) begin
          att_d   = 2'd0;
          state_d = S_WAKE;
        end
      end
      S_CFLAG, S_CDATA: begin
        if (tok_done) begin
          if ((state_q == S_CDATA) && !last_byte) begin
            idx_d   = idx_q + IW'(1);
            state_d = S_CDATA;
          end else if ((state_q == S_CFLAG) && (len_q != '0)) begin
            state_d = S_CDATA;
          end else begin
            tmr_load = 1'b1;
            tmr_val  = long_q ? TW'(T_PARSE) : TW'(T_SHORT);
            state_d  = long_q ? S_PWAIT : S_EWAIT;
          end
        end
      end
      S_PWAIT: if (tmr_exp) state_d = S_PXMIT;
      S_PXMIT: begin
        rx_clr = 1'b1;
        if (tok_done) begin
          tmr_load = 1'b1;
          tmr_val  = TW'(T_TIMEOUT);
          state_d  = S_PRESP;
        end
      end
      S_PRESP: begin
        if (rx_end) begin
          err_d   = ER_PARSE;
          stat_d  = blk_status;
          state_d = S_SLEEP;
        end else if (rx_valid) begin
          tmr_load = 1'b1;
          tmr_val  = TW'(T_TIMEOUT);
        end else if (tmr_exp) begin
          tmr_load = 1'b1;
          tmr_val  = TW'(T_EXEC_LONG);
          state_d  = S_EWAIT;
        end
      end
      S_EWAIT: if (tmr_exp) state_d = S_RXMIT;
      S_RXMIT: begin
        rx_clr = 1'b1;
        if (tok_done) begin
          tmr_load = 1'b1;
          tmr_val  = TW'(T_TIMEOUT);
          state_d  = S_RRESP;
        end
      end
      S_RRESP: begin
        if (rx_end) begin
          stat_d = blk_status;
          if (rx_crc_ok) begin
            if ((blk_count == SHORT_BLOCK) && (blk_status == EXEC_FAIL))      err_d = ER_EXEC;
            else if ((blk_count == SHORT_BLOCK) && (blk_status == COMM_FAIL)) err_d = ER_COMM;
            else                                                              succ_d = 1'b1;
            state_d = S_SLEEP;
          end else if (rd_q == RW'(MAX_REREAD)) begin
            err_d   = ER_COMM;
            state_d = S_SLEEP;
          end else begin
            rd_d    = rd_q + RW'(1);
            state_d = S_RXMIT;
          end
        end else if (rx_valid) begin
          tmr_load = 1'b1;
          tmr_val  = TW'(T_TIMEOUT);
        end else if (tmr_exp) begin
          err_d   = ER_NORESP;
          state_d = S_SLEEP;
        end
      end
      S_SLEEP: if (tok_done) state_d = S_DONE;
      S_DONE:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  // session clock: restarts on every completed wake token, saturates
  always_comb begin
    sess_d = sess_q;
    if ((state_q == S_WAKE) && tok_done) sess_d = '0;
    else if (sess_q != '1)               sess_d = sess_q + SW'(1);
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      state_q <= S_IDLE;
      att_q   <= 2'd0;
      rd_q    <= '0;
      idx_q   <= '0;
      split_q <= 1'b0;
      long_q  <= 1'b0;
      len_q   <= '0;
      err_q   <= ER_NONE;
      succ_q  <= 1'b0;
      stat_q  <= 8'd0;
      sess_q  <= '0;
    end else begin
      state_q <= state_d;
      att_q   <= att_d;
      rd_q    <= rd_d;
      idx_q   <= idx_d;
      split_q <= split_d;
      long_q  <= long_d;
      len_q   <= len_d;
      err_q   <= err_d;
      succ_q  <= succ_d;
      stat_q  <= stat_d;
      sess_q  <= sess_d;
    end
  end

  always_comb begin
    tok_req  = 1'b1;
    tok_kind = TK_WAKE;
    tok_data = 8'd0;
    unique case (state_q)
      S_WAKE:                   tok_kind = TK_WAKE;
      S_WXMIT, S_PXMIT, S_RXMIT: tok_kind = TK_XMIT;
      S_CFLAG:                  tok_kind = TK_CMDF;
      S_SPLIT, S_SLEEP:         tok_kind = TK_SLEEP;
      S_CDATA: begin
        tok_kind = TK_DATA;
        tok_data = buf_rdata;
      end
      default:                  tok_req = 1'b0;
    endcase
  end

  assign busy        = (state_q != S_IDLE);
  assign done        = (state_q == S_DONE);
  assign success     = succ_q;
  assign err_code    = err_q;
  assign resp_status = stat_q;

endmodule

// File: rtl/host_auth_seq_checker.sv
module host_auth_seq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic       success,
  input logic [2:0] err_code,
  input logic       tok_req,
  input logic [2:0] tok_kind,
  input logic [7:0] tok_data,
  input logic       tok_done
);

  a_r10_tok_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_req && !tok_done) |=> (tok_req && $stable(tok_kind) && $stable(tok_data)));

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_done_after_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(tok_done && (tok_kind == 3'd3)));

  a_r6_success_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (done && success) |-> (err_code == 3'd0));

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tok_req);

endmodule

bind host_auth_seq host_auth_seq_checker u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .success(success),
  .err_code(err_code), .tok_req(tok_req), .tok_kind(tok_kind),
  .tok_data(tok_data), .tok_done(tok_done)
);

// File: tb/host_auth_seq_bench.sv
module host_auth_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int BD  = 8;
  localparam int TP  = 20;
  localparam int TEL = 60;
  localparam int TS  = 30;
  localparam int TTO = 16;
  localparam int TWK = 6;
  localparam int TWD = 400;
  localparam int TB  = 10;
  localparam int MR  = 2;
  localparam int IW  = 3;
  localparam int LW  = 4;

  localparam int KW = 0, KX = 1, KC = 2, KS = 3, KD = 4;

  logic clk, rst_n, start, cmd_long, buf_we, tok_req, tok_done;
  logic rx_valid, rx_end, rx_crc_ok, busy, done, success;
  logic [LW-1:0] cmd_len;
  logic [IW-1:0] buf_addr;
  logic [7:0] buf_wdata, tok_data, rx_byte, resp_status;
  logic [2:0] tok_kind, err_code;

  host_auth_seq #(
    .BUF_DEPTH(BD), .T_PARSE(TP), .T_EXEC_LONG(TEL), .T_SHORT(TS), .T_TIMEOUT(TTO),
    .T_WAKE(TWK), .T_WATCHDOG(TWD), .T_BYTE(TB), .MAX_REREAD(MR)
  ) u_host_auth_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_long(cmd_long), .cmd_len(cmd_len),
    .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
    .tok_req(tok_req), .tok_kind(tok_kind), .tok_data(tok_data), .tok_done(tok_done),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_end(rx_end), .rx_crc_ok(rx_crc_ok),
    .busy(busy), .done(done), .success(success), .err_code(err_code),
    .resp_status(resp_status)
  );

  int n_checks = 0, n_errs = 0, cyc = 0;
  int lg_kind[64], lg_data[64], lg_t[64];
  int n_log, xi, lat_x0;
  int rp_mode[16], rp_stat[16], rp_crc[16];
  int ex[64], nex;
  int r_succ, r_err, r_stat;
  logic [7:0] bufv[BD];

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // line driver and device model
  task automatic send_reply(input int i);
    logic [7:0] b;
    if (i < 16 && rp_mode[i] != 0) begin
      repeat (3) @(negedge clk);
      for (int j = 0; j < 4; j++) begin
        b = (j == 0) ? 8'd4 : (j == 1) ? 8'(rp_stat[i]) : (j == 2) ? 8'hA5 : 8'h5A;
        rx_byte = b; rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
      end
      rx_end = 1'b1; rx_crc_ok = (rp_crc[i] != 0);
      @(negedge clk);
      rx_end = 1'b0; rx_crc_ok = 1'b0;
    end
  endtask

  initial begin
    tok_done = 1'b0; rx_valid = 1'b0; rx_end = 1'b0; rx_byte = 8'd0; rx_crc_ok = 1'b0;
    forever begin
      @(negedge clk);
      if (tok_req && rst_n) begin
        int k;
        int lat;
        k = int'(tok_kind);
        if (n_log < 64) begin
          lg_kind[n_log] = k; lg_data[n_log] = int'(tok_data); lg_t[n_log] = cyc;
        end
        n_log++;
        lat = (k == KX && xi == 0) ? lat_x0 : 2;
        repeat (lat) @(negedge clk);
        tok_done = 1'b1;
        @(negedge clk);
        tok_done = 1'b0;
        if (k == KX) begin
          send_reply(xi);
          xi++;
        end
      end
    end
  end

  task automatic clear_plan();
    n_log = 0; xi = 0; lat_x0 = 2; nex = 0;
    for (int i = 0; i < 16; i++) begin
      rp_mode[i] = 0; rp_stat[i] = 0; rp_crc[i] = 1;
    end
  endtask

  task automatic plan(input int i, input int mode, input int st, input int crc);
    rp_mode[i] = mode; rp_stat[i] = st; rp_crc[i] = crc;
  endtask

  task automatic push(input int k);
    ex[nex] = k; nex++;
  endtask

  task automatic wait_done(input string tag);
    int n;
    n = 0;
    while (!done && n < 20000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 20000) chk(1'b0, {tag, " watchdog"}, n, 0);
    r_succ = int'(success); r_err = int'(err_code); r_stat = int'(resp_status);
    @(negedge clk);
  endtask

  task automatic run(input bit lng, input int len, input string tag);
    @(negedge clk);
    cmd_long = lng; cmd_len = LW'(len); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(tag);
  endtask

  // token order and kind codes (R10 encoding) against the expected list
  task automatic chk_seq(input string tag);
    int bad;
    bad = 0;
    chk(n_log == nex, {tag, " token count"}, n_log, nex);
    for (int i = 0; i < nex && i < n_log; i++) if (lg_kind[i] != ex[i]) bad++;
    chk(bad == 0, {tag, " token order R10"}, bad, 0);
  endtask

  function automatic int tk_time(input int k, input int nth);
    int c;
    c = 0;
    for (int i = 0; i < n_log && i < 64; i++) begin
      if (lg_kind[i] == k) begin
        if (c == nth) return lg_t[i];
        c++;
      end
    end
    return -100000;
  endfunction

  function automatic int tk_last_before_x(input int xn);
    int t;
    int c;
    t = -100000; c = 0;
    for (int i = 0; i < n_log && i < 64; i++) begin
      if (lg_kind[i] == KX) begin
        if (c == xn) return t;
        c++;
      end
      t = lg_t[i];
    end
    return t;
  endfunction

  task automatic load_buf();
    for (int i = 0; i < BD; i++) begin
      @(negedge clk);
      bufv[i] = 8'(i * 17 + 3);
      buf_we = 1'b1; buf_addr = IW'(i); buf_wdata = bufv[i];
    end
    @(negedge clk);
    buf_we = 1'b0;
  endtask

  task automatic t_reset();
    chk(!busy && !done && !tok_req, "R8 reset quiet", {busy, done, tok_req}, 0);
    chk(!success && err_code == 0 && resp_status == 0, "R8 reset results",
        {success, err_code}, 0);
  endtask

  task automatic t_short_ok();
    int bad;
    int g;
    clear_plan(); plan(0, 1, 'h11, 1); plan(1, 1, 'h00, 1);
    run(1'b0, 3, "R4 short");
    push(KW); push(KX); push(KC); push(KD); push(KD); push(KD); push(KX); push(KS);
    chk_seq("R1 short sequence");
    bad = 0;
    for (int i = 0; i < 3; i++) if (lg_data[3 + i] != int'(bufv[i])) bad++;
    chk(bad == 0, "R1 data order", bad, 0);
    g = tk_time(KX, 1) - tk_last_before_x(1);
    chk(g >= TS && g < TS + 12, "R4 single wait", g, TS);
    chk(r_succ == 1 && r_err == 0 && r_stat == 0, "R6 success", r_err, 0);
  endtask

  task automatic t_long_ok();
    int g;
    clear_plan(); plan(0, 1, 'h11, 1); plan(1, 0, 0, 1); plan(2, 1, 'h00, 1);
    run(1'b1, 2, "R3 long");
    push(KW); push(KX); push(KC); push(KD); push(KD); push(KX); push(KX); push(KS);
    chk_seq("R3 long sequence");
    g = tk_time(KX, 1) - tk_last_before_x(1);
    chk(g >= TP && g < TP + 8, "R3 parse wait", g, TP);
    g = tk_time(KX, 2) - tk_time(KX, 1);
    chk(g >= TTO + TEL && g < TTO + TEL + 12, "R3 exec wait", g, TTO + TEL);
    chk(r_succ == 1 && r_err == 0, "R3 long result", r_err, 0);
  endtask

  task automatic t_probe_err();
    clear_plan(); plan(0, 1, 'h11, 1); plan(1, 1, 'h0F, 1);
    run(1'b1, 1, "R3 probe");
    push(KW); push(KX); push(KC); push(KD); push(KX); push(KS);
    chk_seq("R3 probe sequence");
    chk(r_err == 2 && r_stat == 'h0F && r_succ == 0, "R3 probe error", r_err, 2);
  endtask

  task automatic t_reread();
    clear_plan(); plan(0, 1, 'h11, 1); plan(1, 1, 'h00, 0); plan(2, 1, 'h00, 1);
    run(1'b0, 1, "R5 reread");
    push(KW); push(KX); push(KC); push(KD); push(KX); push(KX); push(KS);
    chk_seq("R5 reread sequence");
    chk(r_succ == 1 && r_err == 0, "R5 reread recovers", r_err, 0);
  endtask

  task automatic t_reread_exhaust();
    clear_plan(); plan(0, 1, 'h11, 1);
    for (int i = 1; i <= MR + 1; i++) plan(i, 1, 'h00, 0);
    run(1'b0, 1, "R5 exhaust");
    push(KW); push(KX); push(KC); push(KD);
    for (int i = 0; i <= MR; i++) push(KX);
    push(KS);
    chk_seq("R5 exhaust sequence");
    chk(r_err == 4 && r_succ == 0, "R5 exhaust comm failure", r_err, 4);
  endtask

  task automatic t_status_codes();
    clear_plan(); plan(0, 1, 'h11, 1); plan(1, 1, 'h0F, 1);
    run(1'b0, 1, "R6 exec");
    chk(r_err == 3 && r_stat == 'h0F && r_succ == 0, "R6 exec error", r_err, 3);
    clear_plan(); plan(0, 1, 'h11, 1); plan(1, 1, 'hFF, 1);
    run(1'b0, 1, "R6 comm");
    chk(r_err == 4 && r_stat == 'hFF, "R6 comm status", r_err, 4);
    clear_plan(); plan(0, 1, 'h11, 1); plan(1, 1, 'h3C, 1);
    run(1'b0, 1, "R6 data");
    chk(r_succ == 1 && r_stat == 'h3C, "R6 data byte passes", r_stat, 'h3C);
  endtask

  task automatic t_noresp();
    clear_plan(); plan(0, 1, 'h11, 1);
    run(1'b0, 1, "R7 silent");
    push(KW); push(KX); push(KC); push(KD); push(KX); push(KS);
    chk_seq("R7 silent sequence");
    chk(r_err == 5 && r_succ == 0, "R7 no response", r_err, 5);
  endtask

  task automatic t_ladder();
    int g;
    clear_plan(); plan(2, 1, 'h11, 1); plan(3, 1, 'h00, 1);
    run(1'b0, 1, "R2 ladder");
    push(KW); push(KX); push(KW); push(KX); push(KW); push(KX);
    push(KC); push(KD); push(KX); push(KS);
    chk_seq("R2 ladder sequence");
    g = tk_time(KW, 1) - tk_time(KX, 0);
    chk(g >= 2 * TTO && g < 2 * TTO + 12, "R2 first idle", g, 2 * TTO);
    g = tk_time(KW, 2) - tk_time(KX, 1);
    chk(g >= 3 * TTO && g < 3 * TTO + 12, "R2 second idle", g, 3 * TTO);
    chk(r_succ == 1, "R2 ladder recovers", r_err, 0);
  endtask

  task automatic t_nosync();
    int g;
    clear_plan();
    run(1'b0, 1, "R2 nosync");
    for (int i = 0; i < 4; i++) begin push(KW); push(KX); end
    push(KS);
    chk_seq("R2 nosync sequence");
    g = tk_time(KW, 3) - tk_time(KX, 2);
    chk(g >= TTO + TWD && g < TTO + TWD + 12, "R2 watchdog idle", g, TTO + TWD);
    chk(r_err == 1 && r_succ == 0, "R2 no sync", r_err, 1);
  endtask

  task automatic t_split();
    clear_plan(); lat_x0 = 200;
    plan(0, 1, 'h11, 1); plan(1, 1, 'h11, 1); plan(2, 0, 0, 1); plan(3, 1, 'h00, 1);
    run(1'b1, 8, "R9 split");
    push(KW); push(KX); push(KS); push(KW); push(KX); push(KC);
    for (int i = 0; i < 8; i++) push(KD);
    push(KX); push(KX); push(KS);
    chk_seq("R9 split sequence");
    chk(r_succ == 1, "R9 split completes", r_err, 0);
  endtask

  task automatic t_busy_start();
    int nw;
    clear_plan(); plan(0, 1, 'h11, 1); plan(1, 1, 'h00, 1);
    @(negedge clk);
    cmd_long = 1'b0; cmd_len = LW'(1); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done("R11 busy start");
    repeat (40) @(negedge clk);
    nw = 0;
    for (int i = 0; i < n_log; i++) if (lg_kind[i] == KW) nw++;
    chk(nw == 1 && n_log == 6, "R11 start ignored while busy", n_log, 6);
    chk(!busy && !tok_req, "R11 stays idle", busy, 0);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; cmd_long = 1'b0; cmd_len = '0;
    buf_we = 1'b0; buf_addr = '0; buf_wdata = 8'd0;
    clear_plan();
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    load_buf();
    t_short_ok();
    t_long_ok();
    t_probe_err();
    t_reread();
    t_reread_exhaust();
    t_status_codes();
    t_noresp();
    t_ladder();
    t_nosync();
    t_split();
    t_busy_start();
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_errs++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

endmodule